// File: doc/BRIEF.md
# Lock-Protected GPIO Commit Gating

This block holds the four pin-configuration registers of one 8-pin GPIO port: alternate-function select, pull-up enable, pull-down enable and digital enable. A commit mask decides, pin by pin, whether a write to any of these four registers takes effect. Where a mask bit is 0, the old configuration bit stays in place. Where it is 1, the new bit is stored.

The commit mask guards pins whose default use must not be lost by accident, such as debug or non-maskable interrupt pins. The parameter `PROTECT_MASK` marks these pins. Only the marked pins have writable mask bits, and those bits reset to 0. Every other mask bit is tied to 1.

The mask can be changed only while a lock register is unlocked. Software reconfigures a protected pin in three steps: it unlocks the lock register, sets the pin's commit bit, and then writes the configuration register. A simple register bus carries word address, write strobe, write data and combinational read data.

Top module: `gpio_cfg_guard`

## Requirements
- R1: After reset, the lock register at address 0 reads 1 and the commit mask at address 1 reads `~PROTECT_MASK` over 8 bits. Each configuration register reads its reset parameter.
- R2: Writing 0x4C4F434B to address 0 makes it read 0 (unlocked) from the next cycle. Writing any other value makes it read 1 (locked).
- R3: While the lock reads 1, a write to the commit mask leaves it unchanged.
- R4: Commit-mask bits of pins not set in `PROTECT_MASK` always read 1, and writing 0 to them has no effect.
- R5: While unlocked, commit-mask bits of protected pins take the written value.
- R6: In the configuration registers (address 2 alternate function, 3 pull-up, 4 pull-down, 5 digital enable), a bit whose commit-mask bit is 0 keeps its old value on a write.
- R7: In those same registers, a bit whose commit-mask bit is 1 takes the written value, which reads back from the next cycle.
- R8: Bits 31:8 of every register read 0, and writing them has no effect.
- R9: Addresses 6 and 7 read 0, and writes to them change no register. Reads are never blocked by the lock or commit state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |

## Verification
Assertions check on every cycle that:
- a locked commit mask does not move when written;
- unprotected mask bits stay 1;
- a write never changes a configuration bit whose commit bit was 0;
- the key unlocks;
- the upper read bits are 0.

Only the bench scenarios can show two things. The first is that committed bits really take the written value. The second is that the full unlock, commit, write sequence reconfigures a protected pin. The bench shows both by comparing readback against its own register model under random and directed writes.

// File: rtl/gcg_pkg.sv
package gcg_pkg;
  localparam int BUS_W = 32;
  localparam logic [BUS_W-1:0] UNLOCK_KEY = 32'h4C4F434B;

  typedef enum logic [2:0] {
    ADDR_LOCK   = 3'd0,
    ADDR_COMMIT = 3'd1,
    ADDR_ALTFN  = 3'd2,
    ADDR_PULLUP = 3'd3,
    ADDR_PULLDN = 3'd4,
    ADDR_DIGEN  = 3'd5
  } reg_sel_e;

  // Bits under a set mask take the new value, the rest keep the old one.
  function automatic logic [BUS_W-1:0] commit_merge(
    input logic [BUS_W-1:0] old_v,
    input logic [BUS_W-1:0] new_v,
    input logic [BUS_W-1:0] mask
  );
    return (old_v & ~mask) | (new_v & mask);
  endfunction
endpackage

// File: rtl/gcg_lock.sv
module gcg_lock
  import gcg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [BUS_W-1:0] wdata,
  output logic             locked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  locked <= 1'b1;
    else if (wr) locked <= (wdata != UNLOCK_KEY);
  end
endmodule

// File: rtl/gcg_commit.sv
module gcg_commit #(
  parameter int              PINS         = 8,
  parameter logic [PINS-1:0] PROTECT_MASK = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic            locked,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] mask
);
  logic upd;
  assign upd = wr && !locked;

  for (genvar i = 0; i < PINS; i++) begin : g_bit
    if (PROTECT_MASK[i]) begin : g_prot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   mask[i] <= 1'b0;
        else if (upd) mask[i] <= wdata[i];
      end
    end else begin : g_fixed
      assign mask[i] = 1'b1;
    end
  end
endmodule

// File: rtl/gcg_cfg_reg.sv
module gcg_cfg_reg
  import gcg_pkg::*;
#(
  parameter int           W   = 8,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] mask,
  output logic [W-1:0] q
);
  logic [BUS_W-1:0] merged;
  assign merged = commit_merge(BUS_W'(q), BUS_W'(wdata), BUS_W'(mask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST;
    else if (wr) q <= merged[W-1:0];
  end
endmodule

// File: rtl/gpio_cfg_guard.sv
module gpio_cfg_guard
  import gcg_pkg::*;
#(
  parameter int              PINS         = 8,
  parameter logic [PINS-1:0] PROTECT_MASK = 8'h0C,
  parameter logic [PINS-1:0] ALTFN_RST    = 8'h0C,
  parameter logic [PINS-1:0] PULLUP_RST   = 8'h04,
  parameter logic [PINS-1:0] PULLDN_RST   = 8'h00,
  parameter logic [PINS-1:0] DIGEN_RST    = 8'h0C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [2:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata
);
  localparam int NCFG = 4;
  localparam logic [NCFG-1:0][PINS-1:0] CFG_RST =
    {DIGEN_RST, PULLDN_RST, PULLUP_RST, ALTFN_RST};

  reg_sel_e sel;
  logic lock_wr, commit_wr, locked;
  logic [NCFG-1:0] cfg_wr;
  logic [PINS-1:0] commit_mask;
  logic [NCFG-1:0][PINS-1:0] cfg_q;

  assign sel       = reg_sel_e'(bus_addr);
  assign lock_wr   = bus_we && (sel == ADDR_LOCK);
  assign commit_wr = bus_we && (sel == ADDR_COMMIT);
  assign cfg_wr[0] = bus_we && (sel == ADDR_ALTFN);
  assign cfg_wr[1] = bus_we && (sel == ADDR_PULLUP);
  assign cfg_wr[2] = bus_we && (sel == ADDR_PULLDN);
  assign cfg_wr[3] = bus_we && (sel == ADDR_DIGEN);

  gcg_lock u_lock (
    .clk(clk), .rst_n(rst_n), .wr(lock_wr), .wdata(bus_wdata), .locked(locked)
  );

  gcg_commit #(.PINS(PINS), .PROTECT_MASK(PROTECT_MASK)) u_commit (
    .clk(clk), .rst_n(rst_n), .wr(commit_wr), .locked(locked),
    .wdata(bus_wdata[PINS-1:0]), .mask(commit_mask)
  );

  for (genvar i = 0; i < NCFG; i++) begin : g_cfg
    gcg_cfg_reg #(.W(PINS), .RST(CFG_RST[i])) u_reg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr[i]),
      .wdata(bus_wdata[PINS-1:0]), .mask(commit_mask), .q(cfg_q[i])
    );
  end

  always_comb begin
    case (sel)
      ADDR_LOCK:   bus_rdata = BUS_W'(locked);
      ADDR_COMMIT: bus_rdata = BUS_W'(commit_mask);
      ADDR_ALTFN:  bus_rdata = BUS_W'(cfg_q[0]);
      ADDR_PULLUP: bus_rdata = BUS_W'(cfg_q[1]);
      ADDR_PULLDN: bus_rdata = BUS_W'(cfg_q[2]);
      ADDR_DIGEN:  bus_rdata = BUS_W'(cfg_q[3]);
      default:     bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gcg_checker.sv
module gcg_checker
  import gcg_pkg::*;
#(
  parameter int              PINS         = 8,
  parameter logic [PINS-1:0] PROTECT_MASK = 8'h0C
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  lock_wr,
  input logic                  commit_wr,
  input logic [3:0]            cfg_wr,
  input logic                  locked,
  input logic [PINS-1:0]       commit_mask,
  input logic [3:0][PINS-1:0]  cfg_q,
  input logic [BUS_W-1:0]      bus_wdata,
  input logic [BUS_W-1:0]      bus_rdata
);
  a_r2_key_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_wr && bus_wdata == UNLOCK_KEY) |=> !locked);

  a_r2_other_relocks: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_wr && bus_wdata != UNLOCK_KEY) |=> locked);

  a_r3_locked_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_wr && locked) |=> $stable(commit_mask));

  a_r4_unprotected_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_mask & ~PROTECT_MASK) == ~PROTECT_MASK);

  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata >> PINS) == '0);

  for (genvar i = 0; i < 4; i++) begin : g_chk
    a_r6_masked_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr[i] |=> ((cfg_q[i] ^ $past(cfg_q[i])) & ~$past(commit_mask)) == '0);
  end
endmodule

bind gpio_cfg_guard gcg_checker #(.PINS(PINS), .PROTECT_MASK(PROTECT_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .lock_wr(lock_wr), .commit_wr(commit_wr),
  .cfg_wr(cfg_wr), .locked(locked), .commit_mask(commit_mask), .cfg_q(cfg_q),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
);

// File: tb/gpio_cfg_guard_test.sv
module gpio_cfg_guard_test;
  localparam logic [7:0]  PROT = 8'h0C;
  localparam logic [31:0] KEY  = 32'h4C4F434B;
  localparam logic [7:0]  RST_A = 8'h0C, RST_U = 8'h04, RST_D = 8'h00, RST_E = 8'h0C;

  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [2:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  gpio_cfg_guard #(.PINS(8), .PROTECT_MASK(PROT), .ALTFN_RST(RST_A),
    .PULLUP_RST(RST_U), .PULLDN_RST(RST_D), .DIGEN_RST(RST_E)) uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  // bench model
  logic m_lock;
  logic [7:0] m_mask;
  logic [7:0] m_cfg [4];

  function automatic logic [7:0] gate_bits(logic [7:0] old_v, logic [7:0] new_v, logic [7:0] en);
    logic [7:0] r;
    for (int b = 0; b < 8; b++) r[b] = en[b] ? new_v[b] : old_v[b];
    return r;
  endfunction

  function automatic logic [31:0] model_read(logic [2:0] a);
    if (a == 0) return {31'd0, m_lock};
    if (a == 1) return {24'd0, m_mask};
    if (a >= 2 && a <= 5) return {24'd0, m_cfg[a-2]};
    return 32'd0;
  endfunction

  function automatic string tag_of(logic [2:0] a);
    case (a)
      3'd0: return "R2";
      3'd1: return "R3/R4/R5";
      3'd2, 3'd3, 3'd4, 3'd5: return "R6/R7";
      default: return "R9";
    endcase
  endfunction

  task automatic model_reset();
    m_lock = 1; m_mask = ~PROT;
    m_cfg[0] = RST_A; m_cfg[1] = RST_U; m_cfg[2] = RST_D; m_cfg[3] = RST_E;
  endtask

  task automatic do_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
    if (a == 0) m_lock = (d != KEY);
    else if (a == 1) begin
      if (!m_lock) m_mask = (d[7:0] & PROT) | ~PROT;
    end else if (a <= 5) m_cfg[a-2] = gate_bits(m_cfg[a-2], d[7:0], m_mask);
  endtask

  task automatic check_reg(logic [2:0] a, string tag);
    logic [31:0] exp;
    @(negedge clk);
    bus_addr = a;
    #1;
    exp = model_read(a);
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s addr %0d actual %h expected %h", tag, a, bus_rdata, exp);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    #12 rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 6; a++) check_reg(3'(a), "R1");
    // R6: locked, protected bits hold
    do_write(3'd2, 32'h0000_0000); check_reg(3'd2, "R6");
    do_write(3'd5, 32'h0000_00F3); check_reg(3'd5, "R6");
    // R3: commit write while locked
    do_write(3'd0, 32'h1234_5678); do_write(3'd1, 32'hFF); check_reg(3'd1, "R3");
    // R2: unlock
    do_write(3'd0, KEY); check_reg(3'd0, "R2");
    // R4: clearing all mask bits keeps unprotected ones at 1
    do_write(3'd1, 32'h0); check_reg(3'd1, "R4");
    // R5 then R7: full sequence reconfigures protected pins
    do_write(3'd1, 32'hFF); check_reg(3'd1, "R5");
    do_write(3'd2, 32'h0); check_reg(3'd2, "R7");
    do_write(3'd3, 32'h08); check_reg(3'd3, "R7");
    // R2: any other value relocks
    do_write(3'd0, KEY ^ 32'h1); check_reg(3'd0, "R2");
    // R8: upper bits ignored
    do_write(3'd4, 32'hFFFF_FF00); check_reg(3'd4, "R8");
    // R9: unused address
    do_write(3'd6, 32'hFFFF_FFFF); check_reg(3'd6, "R9");
    for (int a = 0; a < 6; a++) check_reg(3'(a), "R9");
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [2:0] a;
      logic [31:0] d;
      a = 3'($urandom % 8);
      d = $urandom;
      if (a == 0 && ($urandom % 2) == 0) d = KEY;
      do_write(a, d);
      check_reg(a, tag_of(a));
      check_reg(3'($urandom % 8), "R8");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule